// File: doc/BRIEF.md
# CAN Frame Start and Bitwise Arbitration Controller

This block opens a CAN frame and carries it through the contention phase on a wired-AND bus, where dominant (0) overrides recessive (1). It watches the sampled receive bit at each sample-point strobe to tell when the bus has gone quiet. A request carrying an 11-bit identifier and a remote flag is captured and held. When the bus is idle, the block drives a dominant start-of-frame bit and then the arbitration field, and compares each driven bit with the bit read back from the bus.

A node that drives recessive but reads dominant has met a higher-priority competitor. It goes recessive at once and keeps its request, then tries again when the bus is next idle. Reading recessive while driving dominant is a fault: the attempt and the request are dropped. After a clean arbitration field, a one-cycle won strobe hands the bus to the downstream frame logic. That logic then supplies the transmit bit until it signals the end of its frame.

Top module: `can_arb_ctrl`

## Requirements
- R1: After reset, tx_bit is 1, bus_idle is 0, req_ready is 1, and arb_won, arb_lost and bit_err are 0.
- R2: bus_idle is 1 exactly when the last 11 sample strobes all saw rx_bit = 1. A sample strobe that sees rx_bit = 0 clears it on the next cycle.
- R3: A captured request starts a frame only on a bit_start_stb cycle in which bus_idle is 1. The first driven bit is a dominant start-of-frame (0).
- R4: After start-of-frame, the next 12 bits are req_id[10] down to req_id[0], then the remote flag (0 = data frame, 1 = remote frame). tx_bit changes to a new frame bit only on the cycle after a bit_start_stb.
- R5: If a sample strobe during arbitration sees rx_bit = 0 while tx_bit is 1, arb_lost pulses for one cycle on the next cycle. From that cycle, tx_bit is 1 until a new attempt starts.
- R6: With arb_lost, lost_idx gives the position in the arbitration field where the loss occurred: 0 is id bit 10, 10 is id bit 0, and 11 is the remote flag.
- R7: If all 12 arbitration bits are sampled without mismatch, arb_won pulses for one cycle. After that, tx_bit takes ds_bit at each bit_start_stb until ds_done is seen at a sample strobe. tx_bit then returns to 1 and req_ready to 1.
- R8: If a sample strobe sees rx_bit = 1 while tx_bit is 0 during start-of-frame or arbitration, bit_err pulses for one cycle and arb_lost stays 0. The request is dropped, tx_bit returns to 1 and req_ready to 1.
- R9: req_valid is captured only while req_ready is 1. A req_valid while req_ready is 0 leaves the pending identifier and flag unchanged.
- R10: After a loss, the request is retained and retried automatically at the next idle bus, without a new req_valid.
- R11: Of two nodes starting in the same bit, the one with the numerically lower {identifier, remote flag} wins, and the winner's bits reach the bus unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_start_stb | input | 1 | One-cycle strobe at the start of each bit |
| sample_stb | input | 1 | One-cycle strobe at the sample point of each bit |
| rx_bit | input | 1 | Bus level read back (0 dominant) |
| req_valid | input | 1 | Transmit request |
| req_id | input | 11 | Identifier of the request |
| req_rtr | input | 1 | Remote flag of the request |
| req_ready | output | 1 | Block can take a request |
| ds_bit | input | 1 | Bit from downstream frame logic after a win |
| ds_done | input | 1 | Downstream frame finished |
| tx_bit | output | 1 | Bus drive (0 dominant) |
| bus_idle | output | 1 | Eleven recessive samples seen in a row |
| arb_won | output | 1 | One-cycle arbitration won strobe |
| arb_lost | output | 1 | One-cycle arbitration lost strobe |
| lost_idx | output | 4 | Arbitration field position of the loss |
| bit_err | output | 1 | One-cycle dominant-read-as-recessive fault |

## Verification
Two events land on the same sample-point edge here. The losing bit is a dominant bus level, so it both raises arb_lost and restarts the idle count that gates the retry. The bench runs a competing node with a lower identifier, or an equal identifier with a data-frame flag, that keeps the bus busy after the loss. A cycle-by-cycle reference model then fixes the exact bit in which the retry's start-of-frame must appear, eleven recessive samples after the competitor stops. A second test overlaps a new req_valid with a pending attempt, and checks that the identifier driven on the retry is still the first one.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ARB   = 2'd2,
    ST_OWN   = 2'd3
  } arb_state_e;
endpackage

// File: rtl/can_idle_det.sv
module can_idle_det #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic rx_bit,
  output logic bus_idle
);
  localparam int CNT_W = $clog2(IDLE_BITS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = sample_stb;

  always_comb begin
    cnt_d = cnt_q;
    if (!rx_bit)
      cnt_d = '0;
    else if (cnt_q != CNT_W'(IDLE_BITS))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign bus_idle = (cnt_q == CNT_W'(IDLE_BITS));

  a_r2_dominant_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !rx_bit) |=> !bus_idle);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && !(sample_stb && !rx_bit)) |=> bus_idle);
endmodule

// File: rtl/can_arb_frame.sv
module can_arb_frame #(
  parameter int ID_W = 11
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [ID_W-1:0]                   id,
  input  logic                              rtr,
  input  logic [$clog2(ID_W + 2)-1:0]       sel,
  output logic                              bit_o
);
  localparam int FRAME_W = ID_W + 2;

  logic [FRAME_W-1:0] order_d, order_q;

  // order_d[k] is the k-th bit put on the bus: SOF, id MSB..LSB, remote flag
  assign order_d[0]         = 1'b0;
  assign order_d[FRAME_W-1] = rtr;
  for (genvar k = 0; k < ID_W; k++) begin : g_order
    assign order_d[1+k] = id[ID_W-1-k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      order_q <= {FRAME_W{1'b1}};
    else if (load)
      order_q <= order_d;
  end

  assign bit_o = order_q[sel];
endmodule

// File: rtl/can_arb_ctrl.sv
module can_arb_ctrl
  import can_arb_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int IDLE_BITS = 11
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bit_start_stb,
  input  logic                              sample_stb,
  input  logic                              rx_bit,
  input  logic                              req_valid,
  input  logic [ID_W-1:0]                   req_id,
  input  logic                              req_rtr,
  output logic                              req_ready,
  input  logic                              ds_bit,
  input  logic                              ds_done,
  output logic                              tx_bit,
  output logic                              bus_idle,
  output logic                              arb_won,
  output logic                              arb_lost,
  output logic [$clog2(ID_W + 1)-1:0]       lost_idx,
  output logic                              bit_err
);
  localparam int ARB_W   = ID_W + 1;
  localparam int FRAME_W = ARB_W + 1;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int LIDX_W  = $clog2(ARB_W);

  arb_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LIDX_W-1:0] lidx_q, lidx_d;
  logic              tx_q, tx_d;
  logic              won_q, won_d, lost_q, lost_d, err_q, err_d;
  logic              load;
  logic              frame_bit;

  can_idle_det #(.IDLE_BITS(IDLE_BITS)) i_idle (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .rx_bit(rx_bit), .bus_idle(bus_idle)
  );

  can_arb_frame #(.ID_W(ID_W)) i_frame (
    .clk(clk), .rst_n(rst_n), .load(load), .id(req_id), .rtr(req_rtr),
    .sel(idx_q), .bit_o(frame_bit)
  );

  assign load = (state_q == ST_READY) && req_valid;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    lidx_d  = lidx_q;
    tx_d    = tx_q;
    won_d   = 1'b0;
    lost_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_READY: begin
        if (req_valid) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (bit_start_stb && bus_idle) begin
          state_d = ST_ARB;
          idx_d   = '0;
          tx_d    = 1'b0;
        end
      end
      ST_ARB: begin
        if (bit_start_stb) begin
          tx_d = frame_bit;
        end else if (sample_stb) begin
          if (tx_q && !rx_bit) begin
            lost_d  = 1'b1;
            lidx_d  = LIDX_W'(idx_q - 1'b1);
            tx_d    = 1'b1;
            state_d = ST_WAIT;
          end else if (!tx_q && rx_bit) begin
            err_d   = 1'b1;
            tx_d    = 1'b1;
            state_d = ST_READY;
          end else if (idx_q == IDX_W'(FRAME_W - 1)) begin
            won_d   = 1'b1;
            state_d = ST_OWN;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_OWN: begin
        if (bit_start_stb) begin
          tx_d = ds_bit;
        end else if (sample_stb && ds_done) begin
          tx_d    = 1'b1;
          state_d = ST_READY;
        end
      end
      default: state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READY;
      idx_q   <= '0;
      lidx_q  <= '0;
      tx_q    <= 1'b1;
      won_q   <= 1'b0;
      lost_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      lidx_q  <= lidx_d;
      tx_q    <= tx_d;
      won_q   <= won_d;
      lost_q  <= lost_d;
      err_q   <= err_d;
    end
  end

  assign req_ready = (state_q == ST_READY);
  assign tx_bit    = tx_q;
  assign arb_won   = won_q;
  assign arb_lost  = lost_q;
  assign bit_err   = err_q;
  assign lost_idx  = lidx_q;

  a_r5_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_won, arb_lost, bit_err}));

  a_r5_recessive_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> tx_bit);

  a_r8_ready_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> (req_ready && tx_bit));

  a_r4_tx_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_start_stb && !sample_stb) |=> $stable(tx_bit));

  a_r3_start_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && bit_start_stb && !bus_idle) |=> tx_bit);

  a_r9_busy_keeps_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !sample_stb) |=> !req_ready);
endmodule

// File: tb/test_can_arb_ctrl.sv
module test_can_arb_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_start_stb = 1'b0, sample_stb = 1'b0;
  logic req_valid = 1'b0, req_rtr = 1'b0;
  logic [10:0] req_id = '0;
  logic ds_bit = 1'b1, ds_done = 1'b0;
  logic req_ready, tx_bit, bus_idle, arb_won, arb_lost, bit_err;
  logic [3:0] lost_idx;
  logic rx_bit;

  logic comp_bit = 1'b1, force_rec = 1'b0;
  logic comp_arm = 1'b0, comp_on = 1'b0;
  logic [31:0] comp_vec = '1;
  int comp_len = 0, comp_k = 0, phase = 3;
  int total = 0, bad = 0, cycles = 0;
  int n_won = 0, n_lost = 0, n_err = 0, last_lidx = -1;

  assign rx_bit = force_rec ? 1'b1 : (tx_bit & comp_bit);

  always #10 clk = ~clk;

  can_arb_ctrl i_can_arb_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_start_stb(bit_start_stb), .sample_stb(sample_stb),
    .rx_bit(rx_bit), .req_valid(req_valid), .req_id(req_id), .req_rtr(req_rtr),
    .req_ready(req_ready), .ds_bit(ds_bit), .ds_done(ds_done), .tx_bit(tx_bit),
    .bus_idle(bus_idle), .arb_won(arb_won), .arb_lost(arb_lost),
    .lost_idx(lost_idx), .bit_err(bit_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // bit timing and competing node, all driven away from the active edge
  always @(negedge clk) begin
    phase = (phase == 3) ? 0 : phase + 1;
    bit_start_stb = rst_n && (phase == 0);
    sample_stb    = rst_n && (phase == 2);
    if (rst_n && phase == 0) begin
      if (comp_on) begin
        if (comp_k < comp_len) comp_bit = comp_vec[31-comp_k];
        else begin comp_bit = 1'b1; comp_on = 1'b0; end
        comp_k++;
      end else if (comp_arm && bus_idle) begin
        comp_arm = 1'b0; comp_on = 1'b1;
        comp_bit = comp_vec[31]; comp_k = 1;
      end
    end
  end

  // behavioural reference model
  int m_cnt, m_st, m_pos, m_lidx;
  bit m_tx, m_won, m_lost, m_err, m_rtr;
  bit [10:0] m_id;

  function automatic bit m_frame(input int k);
    if (k == 0) return 1'b0;
    if (k <= 11) return m_id[11-k];
    return m_rtr;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_pos = 0; m_lidx = 0; m_tx = 1;
      m_won = 0; m_lost = 0; m_err = 0; m_id = '0; m_rtr = 0;
    end else begin
      bit idle_now, rx;
      idle_now = (m_cnt >= 11);
      rx = rx_bit;
      m_won = 0; m_lost = 0; m_err = 0;
      if (sample_stb) m_cnt = rx ? m_cnt + 1 : 0;
      case (m_st)
        0: if (req_valid) begin m_id = req_id; m_rtr = req_rtr; m_st = 1; end
        1: if (bit_start_stb && idle_now) begin m_st = 2; m_pos = 0; m_tx = 0; end
        2: if (bit_start_stb) m_tx = m_frame(m_pos);
           else if (sample_stb) begin
             if (m_tx && !rx) begin m_lost = 1; m_lidx = m_pos - 1; m_tx = 1; m_st = 1; end
             else if (!m_tx && rx) begin m_err = 1; m_tx = 1; m_st = 0; end
             else if (m_pos == 12) begin m_won = 1; m_st = 3; end
             else m_pos++;
           end
        default: if (bit_start_stb) m_tx = ds_bit;
           else if (sample_stb && ds_done) begin m_tx = 1; m_st = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(tx_bit == m_tx, "R3/R4 tx_bit", tx_bit, m_tx);
      chk(bus_idle == (m_cnt >= 11), "R2 bus_idle", bus_idle, m_cnt >= 11);
      chk(arb_won == m_won, "R7 arb_won", arb_won, m_won);
      chk(arb_lost == m_lost, "R5 arb_lost", arb_lost, m_lost);
      chk(bit_err == m_err, "R8 bit_err", bit_err, m_err);
      chk(req_ready == (m_st == 0), "R9 req_ready", req_ready, m_st == 0);
      if (m_lost) chk(lost_idx == m_lidx, "R6 lost_idx", lost_idx, m_lidx);
      if (arb_won) n_won++;
      if (arb_err_seen(bit_err)) n_err++;
      if (arb_lost) begin n_lost++; last_lidx = lost_idx; end
      if (cycles > 100000) begin
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  function automatic bit arb_err_seen(input logic e);
    return e === 1'b1;
  endfunction

  task automatic send_req(input logic [10:0] id, input logic rtr);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_id = id; req_rtr = rtr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load_comp(input logic [10:0] id, input logic rtr, input int len);
    comp_vec = {1'b0, id, rtr, 19'h0};
    comp_len = len;
    comp_arm = 1'b1;
  endtask

  task automatic run_owned;
    ds_bit = 1'b0;
    repeat (8) @(negedge clk);
    ds_bit = 1'b1; ds_done = 1'b1;
    while (!req_ready) @(negedge clk);
    ds_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_bit == 1'b1, "R1 tx_bit reset", tx_bit, 1);
    chk(req_ready == 1'b1, "R1 req_ready reset", req_ready, 1);
    chk(bus_idle == 1'b0, "R1 bus_idle reset", bus_idle, 0);
    chk({arb_won, arb_lost, bit_err} == 3'b000, "R1 strobes reset", {arb_won, arb_lost, bit_err}, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R7: lone node
    send_req(11'h123, 1'b0);
    while (n_won < 1) @(negedge clk);
    run_owned();
    chk(n_won == 1 && n_lost == 0, "R7 lone win", n_won, 1);

    // R5 R6 R10 R9: lower identifier competitor, extra request ignored
    send_req(11'h3A5, 1'b0);
    load_comp(11'h3A1, 1'b0, 17);
    @(negedge clk);
    req_valid = 1'b1; req_id = 11'h7FF; req_rtr = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (n_lost < 1) @(negedge clk);
    chk(last_lidx == 8, "R6 loss at id bit 2", last_lidx, 8);
    while (n_won < 2) @(negedge clk);
    chk(n_lost == 1, "R10 retry won without new request", n_lost, 1);
    run_owned();

    // R6 R11: same identifier, remote loses to data
    send_req(11'h2AA, 1'b1);
    load_comp(11'h2AA, 1'b0, 15);
    while (n_lost < 2) @(negedge clk);
    chk(last_lidx == 11, "R6 R11 loss at remote flag", last_lidx, 11);
    while (n_won < 3) @(negedge clk);
    run_owned();

    // R11: competitor with higher identifier withdraws after last id bit
    send_req(11'h010, 1'b0);
    load_comp(11'h011, 1'b0, 12);
    while (n_won < 4) @(negedge clk);
    chk(n_lost == 2, "R11 lower id wins", n_lost, 2);
    run_owned();

    // R8: stuck-recessive bus during start-of-frame
    force_rec = 1'b1;
    send_req(11'h055, 1'b0);
    while (n_err < 1) @(negedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 request dropped", req_ready, 1);
    chk(n_lost == 2, "R8 no loss reported", n_lost, 2);
    force_rec = 1'b0;
    repeat (60) @(negedge clk);
    chk(n_won == 4 && tx_bit == 1'b1, "R8 no retry after error", n_won, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule